// File: doc/BRIEF.md
# Millisecond Timer with Compare Interrupt

This block keeps a 64-bit count of elapsed milliseconds and raises a level interrupt once that count has caught up with a programmable 64-bit compare value. A prescaler divides the core clock down to a one-millisecond tick. The counter advances by one on each tick. Software reaches both 64-bit registers as pairs of 32-bit words over a simple single-cycle load/store port.

The counter can only be read from the bus. The compare register can be written and read back. A read of the counter's low word captures the counter's high word at that moment, so the high-word read that follows belongs to the same 64-bit value even when a carry crosses the word boundary in between. The interrupt is a plain comparison with no latch. Software drops it by programming a compare value that lies in the future, and it goes low on the next cycle.

Top module: `msTimer`

## Requirements
- R1: After reset the counter equals parameter INIT_TIME (default 0), the prescaler is at its first cycle, the compare register is all ones, the captured high word equals the high word of INIT_TIME, and the interrupt is low.
- R2: The counter increments by exactly one on every CYCLES_PER_MS-th clock edge after reset, and it holds its value on all other edges.
- R3: A read at TIME_BASE (0xFFFF0018) returns counter bits 31:0 in the same cycle and captures counter bits 63:32. A read at TIME_BASE+4 returns the most recently captured high word.
- R4: Writes at CMP_BASE (0xFFFF0020) and CMP_BASE+4 load compare bits 31:0 and bits 63:32 respectively, taking effect at the next edge. Reads at these addresses return those bits.
- R5: The interrupt output is high in exactly those cycles where the compare value is less than or equal to the counter. It follows a compare write or a counter step in the cycle after that edge.
- R6: Writes to TIME_BASE and TIME_BASE+4 change neither the counter nor any other register.
- R7: Read data is zero when the read enable is low or the address matches none of the four word addresses.
- R8: A carry out of counter bit 31 reaches bit 32 on the same tick, and a low-then-high read pair returns a coherent 64-bit value across that carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Store strobe for the current cycle |
| busRdEn | input | 1 | Load strobe for the current cycle |
| busAddr | input | 32 | Byte address of the accessed word |
| busWrData | input | 32 | Store data |
| busRdData | output | 32 | Load data, valid combinationally in the cycle of busRdEn |
| timerIrq | output | 1 | Level interrupt, high while compare <= counter |

## Verification
A prescaler that is off by one shows up as a counter low word that drifts from the expected count within one millisecond period. A compare register or captured high word that is corrupted shows up at the very next read of that word, and it also shows up on the interrupt line in the first cycle where the ordering of compare and counter differs from the expected one. The bench keeps a behavioural model of the counter, prescaler, compare value and captured word. It compares read data and the interrupt on every clock, so any such divergence is reported in the cycle it first becomes visible. The bench starts the counter just below a 32-bit carry so that the carry across the word boundary is covered by low/high read pairs.

// File: rtl/msTimerPkg.sv
package msTimerPkg;
  typedef struct packed {
    logic rdTimeLo;
    logic rdTimeHi;
    logic rdCmpLo;
    logic rdCmpHi;
    logic wrCmpLo;
    logic wrCmpHi;
  } busStrobe_t;
endpackage

// File: rtl/msTimerCtrl.sv
module msTimerCtrl
  import msTimerPkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] TIME_BASE = 32'hFFFF_0018,
  parameter logic [31:0] CMP_BASE  = 32'hFFFF_0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] TIME_LO = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] TIME_HI = ADDR_W'(TIME_BASE + 32'd4);
  localparam logic [ADDR_W-1:0] CMP_LO  = ADDR_W'(CMP_BASE);
  localparam logic [ADDR_W-1:0] CMP_HI  = ADDR_W'(CMP_BASE + 32'd4);

  logic hitTimeLo, hitTimeHi, hitCmpLo, hitCmpHi;

  always_comb begin
    hitTimeLo = (busAddr == TIME_LO);
    hitTimeHi = (busAddr == TIME_HI);
    hitCmpLo  = (busAddr == CMP_LO);
    hitCmpHi  = (busAddr == CMP_HI);
    strobe.rdTimeLo = busRdEn && hitTimeLo;
    strobe.rdTimeHi = busRdEn && hitTimeHi;
    strobe.rdCmpLo  = busRdEn && hitCmpLo;
    strobe.rdCmpHi  = busRdEn && hitCmpHi;
    // Counter words take no store strobe: stores there fall on the floor.
    strobe.wrCmpLo  = busWrEn && hitCmpLo;
    strobe.wrCmpHi  = busWrEn && hitCmpHi;
  end

  // R7: at most one read select per cycle
  p_rd_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdTimeLo, strobe.rdTimeHi, strobe.rdCmpLo, strobe.rdCmpHi}));

  // R6: a store to a counter word raises no store strobe
  p_time_wr_dropped_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == TIME_LO || busAddr == TIME_HI)) |-> !(strobe.wrCmpLo || strobe.wrCmpHi));
endmodule

// File: rtl/msTimerDatapath.sv
module msTimerDatapath
  import msTimerPkg::*;
#(
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CYCLES_PER_MS = 250000,
  parameter logic [63:0] INIT_TIME     = 64'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              timerIrq
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam int unsigned PRE_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic              msTick;
  logic [CNT_W-1:0]  timeCnt;
  logic [CNT_W-1:0]  cmpReg;
  logic [DATA_W-1:0] snapHi;
  logic [1:0]        cmpWrEn;

  assign msTick  = (preCnt == PRE_LAST);
  assign cmpWrEn = {strobe.wrCmpHi, strobe.wrCmpLo};

  always_ff @(posedge clk) begin
    if (!rstN)       preCnt <= '0;
    else if (msTick) preCnt <= '0;
    else             preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       timeCnt <= CNT_W'(INIT_TIME);
    else if (msTick) timeCnt <= timeCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg <= '1;
    end else begin
      for (int w = 0; w < 2; w++) begin
        if (cmpWrEn[w]) cmpReg[w*DATA_W +: DATA_W] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                snapHi <= INIT_TIME[CNT_W-1:DATA_W];
    else if (strobe.rdTimeLo) snapHi <= timeCnt[CNT_W-1:DATA_W];
  end

  assign timerIrq = (cmpReg <= timeCnt);

  always_comb begin
    rdData = ({DATA_W{strobe.rdTimeLo}} & timeCnt[DATA_W-1:0])
           | ({DATA_W{strobe.rdTimeHi}} & snapHi)
           | ({DATA_W{strobe.rdCmpLo}}  & cmpReg[DATA_W-1:0])
           | ({DATA_W{strobe.rdCmpHi}}  & cmpReg[CNT_W-1:DATA_W]);
  end

  // R2: the counter never moves by more than one per edge
  p_time_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (timeCnt - $past(timeCnt)) <= CNT_W'(1));

  // R2: a tick restarts the prescaler
  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    msTick |=> (preCnt == '0));

  // R3: the captured high word changes only on a low-word read
  p_snap_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdTimeLo |=> $stable(snapHi));

  // R4: the compare register holds without a store
  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrCmpLo || strobe.wrCmpHi) |=> $stable(cmpReg));

  // R5: once raised, the interrupt stays up until compare is rewritten
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !strobe.wrCmpLo && !strobe.wrCmpHi && timeCnt != '1) |=> timerIrq);
endmodule

// File: rtl/msTimer.sv
module msTimer
  import msTimerPkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 250000,
  parameter logic [63:0] INIT_TIME     = 64'd0,
  parameter logic [31:0] TIME_BASE     = 32'hFFFF_0018,
  parameter logic [31:0] CMP_BASE      = 32'hFFFF_0020
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        timerIrq
);
  busStrobe_t strobe;

  msTimerCtrl #(
    .ADDR_W(32), .TIME_BASE(TIME_BASE), .CMP_BASE(CMP_BASE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .strobe(strobe)
  );

  msTimerDatapath #(
    .DATA_W(32), .CYCLES_PER_MS(CYCLES_PER_MS), .INIT_TIME(INIT_TIME)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .rdData(busRdData), .timerIrq(timerIrq)
  );
endmodule

// File: tb/test_msTimer.sv
module test_msTimer;
  localparam int unsigned CPM  = 3;
  localparam logic [63:0] INIT = 64'h0000_0000_FFFF_FFF0;
  localparam logic [31:0] TLO = 32'hFFFF_0018, THI = 32'hFFFF_001C;
  localparam logic [31:0] CLO = 32'hFFFF_0020, CHI = 32'hFFFF_0024;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busAddr = '0, busWrData = '0;
  logic [31:0] busRdData;
  logic timerIrq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [63:0] mTime, mCmp;
  logic [31:0] mSnap;
  int mPre;

  always #2 clk = ~clk;

  msTimer #(.CYCLES_PER_MS(CPM), .INIT_TIME(INIT)) i_msTimer (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .timerIrq(timerIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRd(input logic rd, input logic [31:0] addr);
    if (!rd) return '0;
    case (addr)
      TLO: return mTime[31:0];
      THI: return mSnap;
      CLO: return mCmp[31:0];
      CHI: return mCmp[63:32];
      default: return '0;
    endcase
  endfunction

  task automatic modelEdge(input logic wr, input logic rd, input logic [31:0] addr, input logic [31:0] data);
    logic [63:0] oldTime;
    oldTime = mTime;
    if (mPre == CPM - 1) begin mPre = 0; mTime = mTime + 64'd1; end
    else mPre++;
    if (wr && addr == CLO) mCmp[31:0]  = data;
    if (wr && addr == CHI) mCmp[63:32] = data;
    if (rd && addr == TLO) mSnap = oldTime[63:32];
  endtask

  task automatic step(input logic wr, input logic rd, input logic [31:0] addr,
                      input logic [31:0] data, input string tag);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = addr; busWrData = data;
    #1;
    check(tag, busRdData, expRd(rd, addr));
    check("R5 irq", {31'd0, timerIrq}, {31'd0, (mCmp <= mTime)});
    @(posedge clk);
    modelEdge(wr, rd, addr, data);
  endtask

  initial begin
    mTime = INIT; mCmp = '1; mSnap = INIT[63:32]; mPre = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state visible at the ports
    check("R1 irq low", {31'd0, timerIrq}, 32'd0);
    check("R1 idle read", busRdData, 32'd0);
    @(posedge clk);
    modelEdge(1'b0, 1'b0, 32'd0, 32'd0);

    step(0, 1, TLO, 0, "R1 time lo");
    step(0, 1, THI, 0, "R1 snap hi");
    step(0, 1, CLO, 0, "R1 cmp lo");
    step(0, 1, CHI, 0, "R1 cmp hi");

    for (int i = 0; i < 8; i++) step(0, 1, TLO, 0, "R2 tick");
    step(0, 1, THI, 0, "R3 snap");

    begin
      logic [63:0] nc;
      nc = mTime + 64'd4;
      step(1, 0, CHI, nc[63:32], "R4 wr hi");
      step(1, 0, CLO, nc[31:0], "R4 wr lo");
      step(0, 1, CLO, 0, "R4 cmp lo");
      step(0, 1, CHI, 0, "R4 cmp hi");
    end
    for (int i = 0; i < 15; i++) step(0, 0, 32'd0, 0, "R5 wait");

    step(1, 0, CHI, 32'd1, "R5 future");
    step(0, 0, 32'd0, 0, "R5 low");
    step(1, 0, CHI, 32'd0, "R5 past hi");
    step(1, 0, CLO, 32'd0, "R5 past lo");
    step(0, 0, 32'd0, 0, "R5 high");

    step(1, 0, TLO, 32'h1234_5678, "R6 wr lo");
    step(1, 0, THI, 32'hDEAD_BEEF, "R6 wr hi");
    step(0, 1, TLO, 0, "R6 time lo");
    step(0, 1, THI, 0, "R6 time hi");
    step(0, 1, CHI, 0, "R6 cmp kept");

    step(0, 1, 32'hFFFF_0028, 0, "R7 unmapped");
    step(0, 1, 32'hFFFF_0010, 0, "R7 unmapped");
    step(0, 0, TLO, 0, "R7 no rd");

    for (int i = 0; i < 30; i++) begin
      step(0, 1, TLO, 0, "R8 lo");
      step(0, 1, THI, 0, "R8 hi");
    end
    step(0, 1, TLO, 0, "R8 lo");
    check("R8 carried", {31'd0, mTime[32]}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule